// File: doc/BRIEF.md
# Write-Protected Register Front End with Event Status and Interrupt Combining

This block sits between a 32-bit register port and the calendar core of a real-time clock. Every register write, except those to the two kick registers, is refused until software writes two fixed 32-bit keys to the kick registers in the correct order. A wrong value, a partial-width write, or a zero written to either kick register closes the block again at once. Reads are always served, whether the block is open or closed. A refused write is dropped and recorded in a sticky error flag that software can read back.

The block keeps a status register. The calendar core sets its bits through one-cycle event inputs for the one-second tick, the primary alarm and the secondary alarm. Software clears those bits by writing a one to them. An interrupt-enable register, a wake-enable register and a power-control register combine with the status bits to drive two level interrupt lines, a wake request and an active-high power-enable output. That power output drops to its off level when the secondary alarm fires while power control is armed.

Top module: `rtc_regfront`

## Requirements
- R1: After reset the block is locked, every status, enable, wake and power-control bit is 0, `irq_timer`, `irq_alarm` and `wake_req` are low, and `pwr_on` is high.
- R2: Writing 0x83E70B13 with all four byte lanes to offset 0x6C, and then 0x95A4F1E0 with all four lanes to offset 0x70, raises `unlocked`. Writing the second key while locked, with no first key before it, leaves the block locked. Writing the first key again while open restarts the sequence, so the block is locked until the second key follows.
- R3: Any other value written to either kick offset (0 included), or any write there that does not enable all four byte lanes, locks the block on the next edge.
- R4: While locked, writes to every offset other than the two kick offsets change nothing. Register reads return current contents whether the block is locked or open. The kick offsets read as 0.
- R5: A refused write sets the sticky error flag, which is bit 0 of the status register at offset 0x40. It stays set until an open-state write of 1 to bit 0 with byte lane 0 enabled.
- R6: `ev_tick`, `ev_alarm` and `ev_alarm2` set status bits 2, 6 and 7. A bit clears only when an open-state write to offset 0x40 carries a 1 in that bit with byte lane 0 enabled. If an event and a clear reach the same bit in the same cycle, the event wins.
- R7: `irq_timer` is high exactly while status bit 2 and enable bit 2 (interrupt-enable register, offset 0x4C) are both set. It is a level that stays high until either bit is cleared.
- R8: `irq_alarm` is high while (status bit 6 and enable bit 3) or (status bit 7 and enable bit 4) are set.
- R9: `wake_req` is high while status bit 6 and bit 1 of the wake register at offset 0x7C are set.
- R10: When bit 16 of the power register at offset 0x98 is set and status bit 7 is set, `pwr_on` is low. Otherwise it is high.
- R11: Enable bits 2 and 3 are written through byte lane 0. Enable bit 4 changes only on a write with all four byte lanes enabled, so a byte-wide write leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ev_tick | input | 1 | One-second event pulse from the calendar core |
| ev_alarm | input | 1 | Primary alarm match pulse |
| ev_alarm2 | input | 1 | Secondary alarm match pulse |
| unlocked | output | 1 | High while register writes are accepted |
| irq_timer | output | 1 | Periodic tick interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |
| wake_req | output | 1 | Wake request level |
| pwr_on | output | 1 | Power-enable output, low means off |

## Verification
The bench sends the two keys in the wrong order, corrupts the sequence partway through, and sends the second key with only some byte lanes enabled. A design that does not track the order, or that does not check the lanes, would report itself open and accept writes. It clears and re-arms a status bit in the same cycle and expects the event to win, because a design that gives the clear priority would lose an alarm. It also writes the enable register one byte at a time, both to set and to clear it, and expects bit 4 to hold, where a design that ignores the lanes would drop the secondary alarm interrupt. Writes made while locked must leave the enables, the wake bit and the power bit unchanged and must raise the sticky error flag, which a design that leaks locked writes would miss.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lock_st_t;

   localparam int NUM_EV     = 3;
   localparam int EV_TICK    = 0;
   localparam int EV_ALARM   = 1;
   localparam int EV_ALARM2  = 2;
   localparam int EV_BITPOS [NUM_EV] = '{2, 6, 7};

   localparam int ST_ERR_BIT   = 0;
   localparam int IEN_TICK_BIT = 2;
   localparam int IEN_ALM_BIT  = 3;
   localparam int IEN_ALM2_BIT = 4;
   localparam int WAKE_ALM_BIT = 1;
   localparam int PWR_CTL_BIT  = 16;
endpackage

// File: rtl/rtcfe_unlock.sv
module rtcfe_unlock
   import rtcfe_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter logic [31:0] KEY0   = 32'h83E70B13,
   parameter logic [31:0] KEY1   = 32'h95A4F1E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              hit_k0,
   input  logic              hit_k1,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] be,
   output logic              open
);
   localparam int LANES = DATA_W / 8;

   lock_st_t st_q, st_d;
   logic     full_word, good0, good1;

   if (DATA_W != 32) begin : g_chk_dw
      $error("rtcfe_unlock: keys are 32 bits wide");
   end

   assign full_word = (be == {LANES{1'b1}});
   assign good0     = full_word && (wdata == KEY0);
   assign good1     = full_word && (wdata == KEY1);

   always_comb begin
      st_d = st_q;
      if (wr && hit_k0) begin
         st_d = good0 ? LK_HALF : LK_SHUT;
      end else if (wr && hit_k1) begin
         if (good1 && (st_q != LK_SHUT)) st_d = LK_OPEN;
         else                             st_d = LK_SHUT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LK_SHUT;
      else        st_q <= st_d;
   end

   assign open = (st_q == LK_OPEN);

   // R2: opening only ever follows a second-key write
   p_open_after_k1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open) |-> $past(wr && hit_k1 && good1));

   // R3: a bad kick write closes the block
   p_bad_kick_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ((hit_k0 && !good0) || (hit_k1 && !good1))) |=> !open);
endmodule

// File: rtl/rtcfe_evbank.sv
module rtcfe_evbank
   import rtcfe_pkg::*;
#(
   parameter int N = NUM_EV
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         clr_en,
   input  logic [7:0]   clr_byte,
   output logic [N-1:0] q
);
   if (N > NUM_EV) begin : g_chk_n
      $error("rtcfe_evbank: more events than bit positions");
   end

   for (genvar i = 0; i < N; i++) begin : g_ev
      localparam int POS = EV_BITPOS[i];
      logic clr;
      assign clr = clr_en && clr_byte[POS];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= 1'b0;
         else if (ev[i]) q[i] <= 1'b1;
         else if (clr)   q[i] <= 1'b0;
      end

      // R6: an event always lands, even against a same-cycle clear
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> q[i]);

      // R6: without a clear a set bit stays set
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (q[i] && !clr) |=> q[i]);
   end
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
   import rtcfe_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] KEY0      = 32'h83E70B13,
   parameter logic [31:0] KEY1      = 32'h95A4F1E0,
   parameter int          STAT_OFS  = 'h40,
   parameter int          IEN_OFS   = 'h4C,
   parameter int          KICK0_OFS = 'h6C,
   parameter int          KICK1_OFS = 'h70,
   parameter int          WAKE_OFS  = 'h7C,
   parameter int          PWR_OFS   = 'h98
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [3:0]        bus_be,
   output logic [31:0]       bus_rdata,
   input  logic              ev_tick,
   input  logic              ev_alarm,
   input  logic              ev_alarm2,
   output logic              unlocked,
   output logic              irq_timer,
   output logic              irq_alarm,
   output logic              wake_req,
   output logic              pwr_on
);
   localparam int DATA_W  = 32;
   localparam int MAX_OFS = (1 << ADDR_W) - 1;

   if (ADDR_W < 8) begin : g_chk_aw
      $error("rtc_regfront: ADDR_W must reach offset 0x98");
   end
   if (PWR_OFS > MAX_OFS || WAKE_OFS > MAX_OFS) begin : g_chk_ofs
      $error("rtc_regfront: offset beyond address range");
   end

   logic hit_st, hit_ien, hit_k0, hit_k1, hit_wk, hit_pw, hit_kick;
   assign hit_st   = (bus_addr == ADDR_W'(STAT_OFS));
   assign hit_ien  = (bus_addr == ADDR_W'(IEN_OFS));
   assign hit_k0   = (bus_addr == ADDR_W'(KICK0_OFS));
   assign hit_k1   = (bus_addr == ADDR_W'(KICK1_OFS));
   assign hit_wk   = (bus_addr == ADDR_W'(WAKE_OFS));
   assign hit_pw   = (bus_addr == ADDR_W'(PWR_OFS));
   assign hit_kick = hit_k0 || hit_k1;

   rtcfe_unlock #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)) lock_i (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hit_k0(hit_k0), .hit_k1(hit_k1),
      .wdata(bus_wdata), .be(bus_be), .open(unlocked));

   logic wr_ok, wr_refused;
   assign wr_ok      = bus_wr && unlocked && !hit_kick;
   assign wr_refused = bus_wr && !unlocked && !hit_kick;

   logic [NUM_EV-1:0] ev_vec, ev_q;
   assign ev_vec[EV_TICK]   = ev_tick;
   assign ev_vec[EV_ALARM]  = ev_alarm;
   assign ev_vec[EV_ALARM2] = ev_alarm2;

   rtcfe_evbank #(.N(NUM_EV)) evb_i (
      .clk(clk), .rst_n(rst_n), .ev(ev_vec),
      .clr_en(wr_ok && hit_st && bus_be[0]), .clr_byte(bus_wdata[7:0]), .q(ev_q));

   logic err_q, ien_tick, ien_alm, ien_alm2, wk_alm, pwr_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q    <= 1'b0;
         ien_tick <= 1'b0;
         ien_alm  <= 1'b0;
         ien_alm2 <= 1'b0;
         wk_alm   <= 1'b0;
         pwr_ctl  <= 1'b0;
      end else begin
         if (wr_refused)
            err_q <= 1'b1;
         else if (wr_ok && hit_st && bus_be[0] && bus_wdata[ST_ERR_BIT])
            err_q <= 1'b0;
         if (wr_ok && hit_ien && bus_be[0]) begin
            ien_tick <= bus_wdata[IEN_TICK_BIT];
            ien_alm  <= bus_wdata[IEN_ALM_BIT];
         end
         if (wr_ok && hit_ien && (bus_be == 4'hF))
            ien_alm2 <= bus_wdata[IEN_ALM2_BIT];
         if (wr_ok && hit_wk && bus_be[0])
            wk_alm <= bus_wdata[WAKE_ALM_BIT];
         if (wr_ok && hit_pw && bus_be[PWR_CTL_BIT/8])
            pwr_ctl <= bus_wdata[PWR_CTL_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_st) begin
         bus_rdata[ST_ERR_BIT]            = err_q;
         bus_rdata[EV_BITPOS[EV_TICK]]    = ev_q[EV_TICK];
         bus_rdata[EV_BITPOS[EV_ALARM]]   = ev_q[EV_ALARM];
         bus_rdata[EV_BITPOS[EV_ALARM2]]  = ev_q[EV_ALARM2];
      end else if (hit_ien) begin
         bus_rdata[IEN_TICK_BIT] = ien_tick;
         bus_rdata[IEN_ALM_BIT]  = ien_alm;
         bus_rdata[IEN_ALM2_BIT] = ien_alm2;
      end else if (hit_wk) begin
         bus_rdata[WAKE_ALM_BIT] = wk_alm;
      end else if (hit_pw) begin
         bus_rdata[PWR_CTL_BIT] = pwr_ctl;
      end
   end

   assign irq_timer = ev_q[EV_TICK] && ien_tick;
   assign irq_alarm = (ev_q[EV_ALARM] && ien_alm) || (ev_q[EV_ALARM2] && ien_alm2);
   assign wake_req  = ev_q[EV_ALARM] && wk_alm;
   assign pwr_on    = !(pwr_ctl && ev_q[EV_ALARM2]);

   // R4: a locked write leaves every writable control bit alone
   p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_refused |=> $stable({ien_tick, ien_alm, ien_alm2, wk_alm, pwr_ctl}));

   // R5: a refused write raises the sticky error flag
   p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_refused |=> err_q);

   // R11: a partial-lane write never moves the secondary alarm enable
   p_alm2_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ien && bus_be != 4'hF) |=> $stable(ien_alm2));

   // R7: the timer interrupt is a level held while nothing is written
   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_timer && !bus_wr) |=> irq_timer);

   // R10: an armed secondary alarm turns power off
   p_pwr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_ctl && ev_alarm2 && !(bus_wr && hit_pw)) |=> !pwr_on);
endmodule

// File: tb/rtc_regfront_tb.sv
`timescale 1ns/1ps
module rtc_regfront_tb_top;
   localparam logic [31:0] K0 = 32'h83E70B13;
   localparam logic [31:0] K1 = 32'h95A4F1E0;
   localparam logic [7:0] A_ST = 8'h40, A_IEN = 8'h4C, A_K0 = 8'h6C,
                          A_K1 = 8'h70, A_WK = 8'h7C, A_PW = 8'h98;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic ev_tick = 1'b0, ev_alarm = 1'b0, ev_alarm2 = 1'b0;
   logic unlocked, irq_timer, irq_alarm, wake_req, pwr_on;

   always #2.5 clk = ~clk;

   rtc_regfront dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
      .ev_tick(ev_tick), .ev_alarm(ev_alarm), .ev_alarm2(ev_alarm2),
      .unlocked(unlocked), .irq_timer(irq_timer), .irq_alarm(irq_alarm),
      .wake_req(wake_req), .pwr_on(pwr_on));

   typedef struct {
      bit          is_port;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // monitor: pops one expected item per cycle and compares
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_port ? {27'd0, unlocked, irq_timer, irq_alarm, wake_req, pwr_on}
                             : bus_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   // tasks keep the invariant: called and returning 1 ns after a rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.is_port = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk); #1;
   endtask

   // expected vector {unlocked, irq_timer, irq_alarm, wake_req, pwr_on}
   task automatic chk_out(input logic [4:0] e, input string tag);
      item_t it;
      it.is_port = 1'b1; it.exp = {27'd0, e}; it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic pulse(input int which);
      if (which == 0) ev_tick = 1'b1;
      else if (which == 1) ev_alarm = 1'b1;
      else ev_alarm2 = 1'b1;
      @(posedge clk); #1;
      ev_tick = 1'b0; ev_alarm = 1'b0; ev_alarm2 = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      chk_out(5'b00001, "R1 outputs after reset");
      chk_rd(A_ST, 32'h0, "R1 status after reset");
      chk_rd(A_IEN, 32'h0, "R1 enables after reset");

      wr(A_IEN, 32'h1C, 4'hF);
      chk_rd(A_IEN, 32'h0, "R4 locked write dropped");
      chk_rd(A_ST, 32'h1, "R5 error flag set by refused write");
      chk_rd(A_K0, 32'h0, "R4 kick reads zero");

      wr(A_K1, K1, 4'hF);
      wr(A_K0, K0, 4'hF);
      chk_out(5'b00001, "R2 wrong order stays locked");
      wr(A_K1, 32'h1234, 4'hF);
      chk_out(5'b00001, "R3 bad second key locks");
      wr(A_K0, K0, 4'hF);
      wr(A_K1, K1, 4'hF);
      chk_out(5'b10001, "R2 ordered keys unlock");

      wr(A_ST, 32'h1, 4'hF);
      chk_rd(A_ST, 32'h0, "R5 error flag cleared by W1C");

      wr(A_IEN, 32'h1C, 4'h1);
      chk_rd(A_IEN, 32'h0C, "R11 byte write skips bit 4");
      wr(A_IEN, 32'h1C, 4'hF);
      chk_rd(A_IEN, 32'h1C, "R11 full write sets bit 4");
      wr(A_IEN, 32'h00, 4'h1);
      chk_rd(A_IEN, 32'h10, "R11 byte write keeps bit 4");
      wr(A_IEN, 32'h04, 4'hF);
      chk_rd(A_IEN, 32'h04, "R11 full write clears bit 4");

      pulse(0);
      chk_rd(A_ST, 32'h04, "R6 tick sets bit 2");
      chk_out(5'b11001, "R7 timer irq level high");
      chk_out(5'b11001, "R7 timer irq still high");
      wr(A_IEN, 32'h0, 4'hF);
      chk_out(5'b10001, "R7 irq drops with enable");
      wr(A_IEN, 32'h04, 4'hF);
      chk_out(5'b11001, "R7 irq returns with enable");
      wr(A_ST, 32'h04, 4'h1);
      chk_out(5'b10001, "R7 irq drops on W1C");
      chk_rd(A_ST, 32'h0, "R6 tick cleared");

      wr(A_IEN, 32'h08, 4'hF);
      pulse(1);
      chk_out(5'b10101, "R8 alarm irq");
      wr(A_WK, 32'h2, 4'h1);
      chk_out(5'b10111, "R9 wake request");
      wr(A_ST, 32'h40, 4'h2);
      chk_rd(A_ST, 32'h40, "R6 clear needs lane 0");
      ev_alarm = 1'b1;
      wr(A_ST, 32'h40, 4'h1);
      ev_alarm = 1'b0;
      chk_rd(A_ST, 32'h40, "R6 event beats same-cycle clear");
      wr(A_ST, 32'h40, 4'h1);
      chk_out(5'b10001, "R9 alarm cleared outputs");

      wr(A_PW, 32'h0001_0000, 4'hF);
      chk_rd(A_PW, 32'h0001_0000, "R10 power control armed");
      pulse(2);
      chk_out(5'b10000, "R10 power off on secondary alarm");
      chk_rd(A_ST, 32'h80, "R6 secondary alarm bit 7");
      wr(A_IEN, 32'h10, 4'hF);
      chk_out(5'b10100, "R8 secondary alarm irq");
      wr(A_ST, 32'h80, 4'hF);
      chk_out(5'b10001, "R10 power back on after clear");

      wr(A_K0, 32'h0, 4'hF);
      chk_out(5'b00001, "R3 zero kick locks");
      wr(A_WK, 32'h0, 4'hF);
      chk_rd(A_WK, 32'h2, "R4 locked write to wake dropped");
      chk_rd(A_ST, 32'h1, "R5 error flag again");
      wr(A_K0, K0, 4'hF);
      wr(A_K1, K1, 4'h3);
      chk_out(5'b00001, "R3 partial kick keeps locked");
      wr(A_K0, K0, 4'hF);
      wr(A_K1, K1, 4'hF);
      wr(A_K0, K0, 4'hF);
      chk_out(5'b00001, "R2 first key while open restarts");

      repeat (3) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule